// File: doc/BRIEF.md
# Bus-to-FIFO word mover

This block copies a run of 32-bit words between system memory and the local data FIFO of a storage-card host controller. It masters the system bus with AHB-Lite single-word beats inside an incrementing burst, one beat at a time. A register block outside it supplies a start level, a direction, a byte count and a start address. When the run ends, the block sends that register block a one-cycle request to drop the start level.

The FIFO is reached through two valid/ready streams. In the bus-to-FIFO direction the block offers each fetched word on the push stream. It holds the word and its valid until the FIFO takes it, and issues no further bus beat in the meantime. In the FIFO-to-bus direction the block raises ready on the pop stream and takes one word before each bus beat. A FIFO that withholds valid therefore stalls the run. The block also keeps three sticky interrupts: FIFO full, FIFO empty and run finished. Each has its own generation gate and its own clear pulse.

Top module: `fifo_bus_dma`

## Requirements
- R1: After reset, the bus transfer type is IDLE (2'b00), and go_clr, wr_valid, rd_ready and all three interrupts are low.
- R2: A run starts on a rising edge of cfg_go. Byte count, address and direction are captured at that edge, and later changes to them do not alter the running transfer.
- R3: A run makes ceil(cfg_bytes/4) beats. The first beat goes to cfg_addr with its two low bits cleared, and each later beat goes 4 bytes higher. Every beat has HSIZE 3'b010 (word) and HBURST 3'b001 (incrementing).
- R4: A beat's type is NONSEQ (2'b10) when it is the run's first beat or its address sits on a 1 KB boundary, and SEQ (2'b11) otherwise. Between beats of an open burst the type is BUSY (2'b01), and outside a run it is IDLE.
- R5: With cfg_dir = 0, HWRITE is 0 and each word read from the bus appears on wr_data with wr_valid. Word and valid are held until wr_ready, and no further beat starts before that.
- R6: With cfg_dir = 1, HWRITE is 1 and one word is taken through rd_valid/rd_ready before each beat. That word is driven on HWDATA in the beat's data phase, so the bus receives the FIFO words in order.
- R7: While HREADY is low, address, transfer type and control are held in the address phase, and HWDATA is held in the data phase.
- R8: At the end of a run, go_clr is high for exactly one cycle. A byte count of 0 gives this pulse with no bus beat.
- R9: irq_done is set at the end of a run only when gen_done_en is high.
- R10: irq_full and irq_empty are set on a rising edge of fifo_full and fifo_empty respectively, only when their own gen_*_en input is high.
- R11: Each interrupt stays set until its own clear pulse. A set event in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_go | input | 1 | Start level from the register block |
| cfg_dir | input | 1 | 0: bus to FIFO, 1: FIFO to bus |
| cfg_bytes | input | 16 | Run length in bytes |
| cfg_addr | input | 32 | First bus address |
| go_clr | output | 1 | One-cycle request to clear cfg_go |
| gen_full_en | input | 1 | Gate for the FIFO-full interrupt |
| gen_empty_en | input | 1 | Gate for the FIFO-empty interrupt |
| gen_done_en | input | 1 | Gate for the finish interrupt |
| fifo_full | input | 1 | FIFO full level |
| fifo_empty | input | 1 | FIFO empty level |
| clr_full | input | 1 | Clear pulse for irq_full |
| clr_empty | input | 1 | Clear pulse for irq_empty |
| clr_done | input | 1 | Clear pulse for irq_done |
| irq_full | output | 1 | Sticky FIFO-full interrupt |
| irq_empty | output | 1 | Sticky FIFO-empty interrupt |
| irq_done | output | 1 | Sticky finish interrupt |
| wr_valid | output | 1 | Push stream valid |
| wr_ready | input | 1 | Push stream ready |
| wr_data | output | 32 | Push stream word |
| rd_valid | input | 1 | Pop stream valid |
| rd_ready | output | 1 | Pop stream ready |
| rd_data | input | 32 | Pop stream word |
| m_haddr | output | 32 | Bus address |
| m_htrans | output | 2 | Bus transfer type |
| m_hwrite | output | 1 | Bus write flag |
| m_hsize | output | 3 | Bus beat size |
| m_hburst | output | 3 | Bus burst type |
| m_hwdata | output | 32 | Bus write data |
| m_hrdata | input | 32 | Bus read data |
| m_hready | input | 1 | Bus ready |

## Verification
A wrong word counter shows up at the end of the run as a beat too many or too few, or as a go_clr pulse at the wrong time. A wrong address register shows up on the very next beat, as an address off its +4 step or as a NONSEQ/SEQ type that does not fit the 1 KB rule. A stall that is handled wrongly changes HADDR, HTRANS, HWDATA or wr_data in the cycle after a low ready, and the memory or FIFO contents then differ at the end of the run. A wrong interrupt gate or latch shows up on the irq pin one cycle after the event or clear that caused it.

// File: rtl/dma_mover_pkg.sv
package dma_mover_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_ADDR, ST_DATA, ST_PUSH, ST_DONE
  } dma_st_e;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;
  localparam logic [2:0] BURST_INCR = 3'b001;

  localparam int unsigned IRQ_N    = 3;
  localparam int unsigned IRQ_FULL = 0;
  localparam int unsigned IRQ_EMPTY = 1;
  localparam int unsigned IRQ_DONE = 2;
endpackage

// File: rtl/dma_irq_latch.sv
module dma_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic gen_en,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               irq <= 1'b0;
    else if (trig && gen_en)  irq <= 1'b1;
    else if (clr)             irq <= 1'b0;
  end

  // R11: stays set until its clear arrives
  p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq);
  // R9 / R10: nothing but a gated event sets it
  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(trig && gen_en)) |=> !irq);
endmodule

// File: rtl/dma_beat_engine.sv
module dma_beat_engine
  import dma_mover_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned BYTES_W = 16,
  parameter int unsigned BOUND_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              dir,
  input  logic [BYTES_W-1:0] bytes,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [DATA_W-1:0] hwdata,
  input  logic [DATA_W-1:0] hrdata,
  input  logic              hready,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_ready,
  output logic              done
);
  localparam int unsigned STEP      = DATA_W / 8;
  localparam int unsigned SIZE_CODE = $clog2(STEP);
  localparam int unsigned CNT_W     = BYTES_W + 1;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(STEP - 1);

  dma_st_e           st;
  logic              go_q, dir_q, opened;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  left, words;
  logic [DATA_W-1:0] wbuf, rbuf;
  logic              start, on_bound;

  assign start    = go && !go_q;
  assign words    = ({1'b0, bytes} + CNT_W'(STEP - 1)) >> SIZE_CODE;
  assign on_bound = (cur_addr[BOUND_W-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      go_q     <= 1'b0;
      dir_q    <= 1'b0;
      opened   <= 1'b0;
      cur_addr <= '0;
      left     <= '0;
      wbuf     <= '0;
      rbuf     <= '0;
    end else begin
      go_q <= go;
      unique case (st)
        ST_IDLE: if (start) begin
          cur_addr <= base & ALIGN_MASK;
          dir_q    <= dir;
          left     <= words;
          opened   <= 1'b0;
          if (words == '0) st <= ST_DONE;
          else             st <= dir ? ST_FETCH : ST_ADDR;
        end
        ST_FETCH: if (rd_valid) begin
          wbuf <= rd_data;
          st   <= ST_ADDR;
        end
        ST_ADDR: if (hready) begin
          opened   <= 1'b1;
          cur_addr <= cur_addr + ADDR_W'(STEP);
          st       <= ST_DATA;
        end
        ST_DATA: if (hready) begin
          left <= left - CNT_W'(1);
          if (!dir_q) begin
            rbuf <= hrdata;
            st   <= ST_PUSH;
          end else begin
            st <= (left == CNT_W'(1)) ? ST_DONE : ST_FETCH;
          end
        end
        ST_PUSH: if (wr_ready) begin
          st <= (left == '0) ? ST_DONE : ST_ADDR;
        end
        default: begin
          opened <= 1'b0;
          st     <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    unique case (st)
      ST_ADDR: htrans = (!opened || on_bound) ? TR_NONSEQ : TR_SEQ;
      ST_DATA: htrans = (opened && left > CNT_W'(1)) ? TR_BUSY : TR_IDLE;
      ST_FETCH, ST_PUSH: htrans = (opened && left != '0) ? TR_BUSY : TR_IDLE;
      default: htrans = TR_IDLE;
    endcase
  end

  assign haddr    = cur_addr;
  assign hwrite   = dir_q;
  assign hsize    = 3'(SIZE_CODE);
  assign hburst   = BURST_INCR;
  assign hwdata   = wbuf;
  assign wr_valid = (st == ST_PUSH);
  assign wr_data  = rbuf;
  assign rd_ready = (st == ST_FETCH);
  assign done     = (st == ST_DONE);

  // R7: address phase frozen under a wait state
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR && !hready) |=> ($stable(haddr) && $stable(htrans) && $stable(hwrite)));
  // R7: write data frozen in a stalled data phase
  p_wdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && !hready) |=> $stable(hwdata));
  // R5: push stream keeps its word until taken
  p_push_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));
  // R3: every active beat is word sized and word aligned
  p_word_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    htrans[1] |-> (hsize == 3'(SIZE_CODE) && haddr[SIZE_CODE-1:0] == '0));
  // R8: finish request lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: never pop and push in the same cycle
  p_one_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_ready));
endmodule

// File: rtl/fifo_bus_dma.sv
module fifo_bus_dma
  import dma_mover_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned BYTES_W = 16,
  parameter int unsigned BOUND_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_go,
  input  logic               cfg_dir,
  input  logic [BYTES_W-1:0] cfg_bytes,
  input  logic [ADDR_W-1:0]  cfg_addr,
  output logic               go_clr,
  input  logic               gen_full_en,
  input  logic               gen_empty_en,
  input  logic               gen_done_en,
  input  logic               fifo_full,
  input  logic               fifo_empty,
  input  logic               clr_full,
  input  logic               clr_empty,
  input  logic               clr_done,
  output logic               irq_full,
  output logic               irq_empty,
  output logic               irq_done,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [DATA_W-1:0]  wr_data,
  input  logic               rd_valid,
  output logic               rd_ready,
  input  logic [DATA_W-1:0]  rd_data,
  output logic [ADDR_W-1:0]  m_haddr,
  output logic [1:0]         m_htrans,
  output logic               m_hwrite,
  output logic [2:0]         m_hsize,
  output logic [2:0]         m_hburst,
  output logic [DATA_W-1:0]  m_hwdata,
  input  logic [DATA_W-1:0]  m_hrdata,
  input  logic               m_hready
);
  logic             run_done;
  logic             full_q, empty_q;
  logic [IRQ_N-1:0] trig_v, gen_v, clr_v, irq_v;

  dma_beat_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTES_W(BYTES_W), .BOUND_W(BOUND_W)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .go(cfg_go), .dir(cfg_dir), .bytes(cfg_bytes), .base(cfg_addr),
    .haddr(m_haddr), .htrans(m_htrans), .hwrite(m_hwrite), .hsize(m_hsize),
    .hburst(m_hburst), .hwdata(m_hwdata), .hrdata(m_hrdata), .hready(m_hready),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
    .done(run_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      empty_q <= 1'b0;
    end else begin
      full_q  <= fifo_full;
      empty_q <= fifo_empty;
    end
  end

  assign trig_v[IRQ_FULL]  = fifo_full && !full_q;
  assign trig_v[IRQ_EMPTY] = fifo_empty && !empty_q;
  assign trig_v[IRQ_DONE]  = run_done;
  assign gen_v  = {gen_done_en, gen_empty_en, gen_full_en};
  assign clr_v  = {clr_done, clr_empty, clr_full};

  for (genvar i = 0; i < IRQ_N; i++) begin : g_irq
    dma_irq_latch u_latch (
      .clk(clk), .rst_n(rst_n), .trig(trig_v[i]), .gen_en(gen_v[i]),
      .clr(clr_v[i]), .irq(irq_v[i])
    );
  end

  assign irq_full  = irq_v[IRQ_FULL];
  assign irq_empty = irq_v[IRQ_EMPTY];
  assign irq_done  = irq_v[IRQ_DONE];
  assign go_clr    = run_done;

  // R1 / R8: finish request never coincides with an active beat
  p_clr_idle_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go_clr |-> !m_htrans[1]);
endmodule

// File: tb/tb_fifo_bus_dma.sv
module tb_fifo_bus_dma;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_go = 0, cfg_dir = 0;
  logic [15:0] cfg_bytes = 0;
  logic [31:0] cfg_addr = 0;
  logic        go_clr;
  logic        gen_full_en = 1, gen_empty_en = 1, gen_done_en = 1;
  logic        fifo_full = 0, fifo_empty = 0;
  logic        clr_full = 0, clr_empty = 0, clr_done = 0;
  logic        irq_full, irq_empty, irq_done;
  logic        wr_valid, wr_ready, rd_valid, rd_ready;
  logic [31:0] wr_data, rd_data;
  logic [31:0] m_haddr, m_hwdata, m_hrdata;
  logic [1:0]  m_htrans;
  logic        m_hwrite, m_hready;
  logic [2:0]  m_hsize, m_hburst;

  fifo_bus_dma dut (.*);

  int tests = 0, fails = 0;
  logic [31:0] mem [256];
  logic [31:0] gold [256];
  logic [31:0] src_mem [256];
  logic [31:0] sink_mem [256];
  int src_i = 0, sink_n = 0, beat_n = 0, bad_beats = 0, hold_err = 0, push_err = 0;
  logic [31:0] exp_base = 0;
  logic        exp_dir = 0;
  logic        dp_v = 0, dp_w = 0;
  logic [7:0]  dp_a = 0;
  logic        stall_q = 0, pstall_q = 0;
  logic [31:0] stall_addr = 0, pstall_data = 0;
  logic [1:0]  stall_tr = 0;

  assign m_hrdata = mem[dp_a];
  assign rd_data  = src_mem[src_i[7:0]];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus slave and beat monitor
  always @(posedge clk) begin
    if (!rst_n) begin
      dp_v <= 0; m_hready <= 1;
    end else begin
      if (stall_q && (m_haddr != stall_addr || m_htrans != stall_tr)) hold_err <= hold_err + 1;
      stall_q <= m_htrans[1] && !m_hready;
      stall_addr <= m_haddr; stall_tr <= m_htrans;
      if (m_hready) begin
        if (dp_v && dp_w) mem[dp_a] <= m_hwdata;
        dp_v <= m_htrans[1]; dp_w <= m_hwrite; dp_a <= m_haddr[9:2];
        if (m_htrans[1]) begin
          if (m_haddr != exp_base + 32'(4 * beat_n) || m_hwrite != exp_dir ||
              m_hsize != 3'b010 || m_hburst != 3'b001 ||
              m_htrans != (((beat_n == 0) || (m_haddr[9:0] == 0)) ? 2'b10 : 2'b11))
            bad_beats <= bad_beats + 1;
          beat_n <= beat_n + 1;
        end
      end
      m_hready <= ($urandom % 4) != 0;
    end
  end

  // FIFO models
  always @(posedge clk) begin
    if (!rst_n) begin
      wr_ready <= 0; rd_valid <= 0;
    end else begin
      if (pstall_q && (!wr_valid || wr_data != pstall_data)) push_err <= push_err + 1;
      pstall_q <= wr_valid && !wr_ready;
      pstall_data <= wr_data;
      if (wr_valid && wr_ready) begin
        sink_mem[sink_n[7:0]] <= wr_data; sink_n <= sink_n + 1;
      end
      if (rd_valid && rd_ready) src_i <= src_i + 1;
      wr_ready <= ($urandom % 3) != 0;
      rd_valid <= ($urandom % 3) != 0;
    end
  end

  task automatic run(input bit dir, input int bytes, input logic [31:0] addr,
                     input bit gen, input bit disturb);
    int words, cyc;
    bit seen;
    words = (bytes + 3) / 4;
    @(negedge clk);
    beat_n = 0; sink_n = 0; src_i = 0; bad_beats = 0; hold_err = 0; push_err = 0;
    exp_base = {addr[31:2], 2'b00}; exp_dir = dir;
    for (int i = 0; i < 256; i++) begin
      mem[i] = $urandom; src_mem[i] = $urandom;
      gold[i] = dir ? src_mem[i] : mem[i];
    end
    cfg_dir = dir; cfg_bytes = 16'(bytes); cfg_addr = addr; gen_done_en = gen;
    cfg_go = 1;
    @(negedge clk);
    if (disturb) begin cfg_bytes = 16'($urandom); cfg_addr = $urandom; cfg_dir = ~dir; end
    cyc = 0; seen = go_clr;
    while (!seen && cyc < 20000) begin @(negedge clk); cyc++; seen = go_clr; end
    check(seen, "R8 finish pulse", 32'(seen), 1);
    cfg_go = 0;
    @(negedge clk);
    check(!go_clr, "R8 pulse width", 32'(go_clr), 0);
    check(irq_done == gen, "R9 done gate", 32'(irq_done), 32'(gen));
    check(beat_n == words, "R3 beat count (R2 capture)", 32'(beat_n), 32'(words));
    check(bad_beats == 0, "R4 beat addr/type", 32'(bad_beats), 0);
    check(hold_err == 0, "R7 wait hold", 32'(hold_err), 0);
    if (!dir) begin
      check(push_err == 0, "R5 push hold", 32'(push_err), 0);
      check(sink_n == words, "R5 pushed words", 32'(sink_n), 32'(words));
      for (int k = 0; k < words && k < 256; k++)
        if (sink_mem[k] != gold[(exp_base[9:2] + k) % 256])
          check(0, "R5 data", sink_mem[k], gold[(exp_base[9:2] + k) % 256]);
    end else begin
      check(src_i == words, "R6 popped words", 32'(src_i), 32'(words));
      repeat (2) @(negedge clk);
      for (int k = 0; k < words && k < 256; k++)
        if (mem[(exp_base[9:2] + k) % 256] != gold[k])
          check(0, "R6 data", mem[(exp_base[9:2] + k) % 256], gold[k]);
    end
    clr_done = 1; @(negedge clk); clr_done = 0;
    @(negedge clk);
    check(!irq_done, "R11 done clear", 32'(irq_done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(m_htrans == 2'b00 && !go_clr && !wr_valid && !rd_ready &&
          !irq_full && !irq_empty && !irq_done, "R1 reset state",
          {m_htrans, go_clr, wr_valid, rd_ready, irq_full, irq_empty, irq_done}, 0);

    run(0, 16, 32'h1000_0100, 1, 0);
    run(1, 16, 32'h1000_0200, 1, 0);
    run(0, 5, 32'h2000_0043, 1, 0);      // R3 round up, unaligned address
    run(1, 0, 32'h0000_0010, 1, 0);      // R8 zero size
    run(0, 16, 32'h0000_03F8, 1, 0);     // R4 1 KB boundary
    run(1, 24, 32'h0000_07F0, 1, 0);     // R4 boundary, write side
    run(0, 32, 32'h0000_0080, 0, 1);     // R2 disturb, R9 gate off
    run(1, 12, 32'h0000_0020, 1, 1);     // R2 disturb on write side
    for (int n = 0; n < 6; n++)
      run(1'($urandom), int'($urandom % 200), {22'($urandom), 8'($urandom), 2'b00}, 1'($urandom), 0);

    // R10 / R11 on the FIFO interrupts
    @(negedge clk); gen_full_en = 1; fifo_full = 1;
    @(negedge clk);
    check(irq_full, "R10 full set", 32'(irq_full), 1);
    clr_full = 1; @(negedge clk); clr_full = 0; @(negedge clk);
    check(!irq_full, "R11 full clear while level high", 32'(irq_full), 0);
    fifo_full = 0; gen_full_en = 0; @(negedge clk); fifo_full = 1;
    repeat (2) @(negedge clk);
    check(!irq_full, "R10 full gated off", 32'(irq_full), 0);
    gen_empty_en = 1; fifo_empty = 1; clr_empty = 1;
    @(negedge clk); clr_empty = 0;
    check(irq_empty, "R11 set wins over clear", 32'(irq_empty), 1);
    repeat (3) @(negedge clk);
    check(irq_empty, "R11 empty sticky", 32'(irq_empty), 1);
    fifo_empty = 0; clr_empty = 1; @(negedge clk); clr_empty = 0; @(negedge clk);
    check(!irq_empty, "R11 empty clear", 32'(irq_empty), 0);
    gen_empty_en = 0; fifo_empty = 1; repeat (2) @(negedge clk);
    check(!irq_empty, "R10 empty gated off", 32'(irq_empty), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule